// File: doc/BRIEF.md
# Paged External Data Memory Controller

This block carries out single-byte reads and writes to an external data memory on behalf of a small 8-bit processor core. It keeps two independent data-pointer sets. Each set is a page byte, a high byte and a low byte, and together they make a 24-bit address that reaches 16 MB. Changing only the page byte moves the core to another 64 KB segment. For register-indirect accesses, the core supplies the low address byte. A dedicated register gives the middle byte, and the page byte of the current pointer set gives the top byte.

The core loads the pointers, the indirect upper-address register, a strobe-stretch register and a pointer-select bit through a small register port. It then issues a request. The request names the direction, the addressing mode, the low index byte and the write data. The block latches the request, drives the address and runs a read or write strobe lasting 1 to 8 clocks. It drives the data bus during writes. It ends every transfer with a one-cycle completion pulse. A read returns its data together with that pulse.

Top module: `xmem_pager`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `mem_rd`, `mem_wr` and `mem_drive` are 0, and every register reads 0.
- R2: Register codes on `reg_sel`: 0 pointer low, 1 pointer high, 2 pointer page (all three belong to the selected set), 3 indirect upper address, 4 stretch in bits [2:0] with upper bits reading 0, 5 pointer select in bit 0. A write with `reg_we` high takes effect at the clock edge. `reg_rdata` shows the addressed register in the same cycle. Codes 6 and 7 read 0, and writes to them change nothing.
- R3: The pointer-select bit picks which of the two pointer sets codes 0 to 2 and data-pointer accesses use. The two sets keep their contents independently.
- R4: A data-pointer-mode request (`req_indirect`=0) drives `mem_addr` = {page, high, low} of the selected set.
- R5: A register-indirect request (`req_indirect`=1) drives `mem_addr` = {page of the selected set, indirect upper register, `req_idx`}.
- R6: A request accepted at edge k gives one setup cycle. The strobe follows from the next cycle for stretch+1 cycles. The strobe is `mem_rd` for a read and `mem_wr` for a write, and the two are never high together.
- R7: During a write, `mem_drive` is high from the setup cycle through the cycle after the strobe, and `mem_wdata` carries the request data. At all other times `mem_drive` is 0.
- R8: Read data is sampled on the last strobe cycle. It appears on `rdata` in the cycle right after the strobe, with `done` high for exactly that one cycle. A write gives the same `done` pulse.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. A request presented while `busy` is high, including in the `done` cycle, is ignored. A request held high is accepted again in the first idle cycle.
- R10: The address, direction, write data and stretch value are latched at acceptance. Register writes during a transfer do not change it, and `mem_addr` stays stable while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register code |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Addressed register value |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 write, 0 read |
| req_indirect | input | 1 | 1 register-indirect, 0 data-pointer mode |
| req_idx | input | 8 | Low address byte for indirect mode |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read result, valid with done |
| mem_addr | output | 24 | External address |
| mem_wdata | output | 8 | Output data bus |
| mem_drive | output | 1 | Data bus drive enable (tri-state control) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Input data bus |

## Verification
The hardest case to reach from the ports is a request that meets the transfer's last cycle. `busy` is still high in the `done` cycle, so a request there must be dropped and accepted one cycle later. The stimulus holds `req_valid` high across a whole short transfer so that it sweeps through every busy cycle, including the `done` cycle, and the bench counts `done` pulses to confirm exactly one extra acceptance. Register writes are also issued in the middle of a long strobe, which shows that the latched address and stretch cannot be disturbed.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

   typedef enum logic [1:0] {
      XS_IDLE   = 2'd0,
      XS_SETUP  = 2'd1,
      XS_STROBE = 2'd2,
      XS_TAIL   = 2'd3
   } xfer_state_t;

   localparam logic [2:0] RSEL_PLOW    = 3'd0;
   localparam logic [2:0] RSEL_PHIGH   = 3'd1;
   localparam logic [2:0] RSEL_PPAGE   = 3'd2;
   localparam logic [2:0] RSEL_IHI     = 3'd3;
   localparam logic [2:0] RSEL_STRETCH = 3'd4;
   localparam logic [2:0] RSEL_PSEL    = 3'd5;

endpackage

// File: rtl/xmem_ptr_regs.sv
module xmem_ptr_regs
   import xmem_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_PTR   = 2,
   parameter int STRETCH_W = 3,
   parameter int SEL_W     = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [2:0]           sel,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic [DATA_W-1:0]    cur_low,
   output logic [DATA_W-1:0]    cur_high,
   output logic [DATA_W-1:0]    cur_page,
   output logic [DATA_W-1:0]    ind_hi,
   output logic [STRETCH_W-1:0] stretch
);

   logic [DATA_W-1:0]    low_arr  [NUM_PTR];
   logic [DATA_W-1:0]    high_arr [NUM_PTR];
   logic [DATA_W-1:0]    page_arr [NUM_PTR];
   logic [SEL_W-1:0]     psel_q;
   logic [DATA_W-1:0]    ihi_q;
   logic [STRETCH_W-1:0] stretch_q;

   // one register set per pointer; only the selected set accepts writes
   for (genvar g = 0; g < NUM_PTR; g++) begin : g_set
      logic [DATA_W-1:0] lo_q, hi_q, pg_q;
      logic              hit;

      assign hit = we && (psel_q == SEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            pg_q <= '0;
         end else if (hit) begin
            case (sel)
               RSEL_PLOW:  lo_q <= wdata;
               RSEL_PHIGH: hi_q <= wdata;
               RSEL_PPAGE: pg_q <= wdata;
               default: ;
            endcase
         end
      end

      assign low_arr[g]  = lo_q;
      assign high_arr[g] = hi_q;
      assign page_arr[g] = pg_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psel_q    <= '0;
         ihi_q     <= '0;
         stretch_q <= '0;
      end else if (we) begin
         case (sel)
            RSEL_IHI:     ihi_q     <= wdata;
            RSEL_STRETCH: stretch_q <= wdata[STRETCH_W-1:0];
            RSEL_PSEL: begin
               if (int'(wdata[SEL_W-1:0]) < NUM_PTR) psel_q <= wdata[SEL_W-1:0];
            end
            default: ;
         endcase
      end
   end

   assign cur_low  = low_arr[psel_q];
   assign cur_high = high_arr[psel_q];
   assign cur_page = page_arr[psel_q];
   assign ind_hi   = ihi_q;
   assign stretch  = stretch_q;

   always_comb begin
      rdata = '0;
      case (sel)
         RSEL_PLOW:    rdata = cur_low;
         RSEL_PHIGH:   rdata = cur_high;
         RSEL_PPAGE:   rdata = cur_page;
         RSEL_IHI:     rdata = ihi_q;
         RSEL_STRETCH: rdata[STRETCH_W-1:0] = stretch_q;
         RSEL_PSEL:    rdata[SEL_W-1:0] = psel_q;
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/xmem_addr_form.sv
module xmem_addr_form #(
   parameter int DATA_W        = 8,
   parameter bit INDIRECT_PAGE = 1'b1
) (
   input  logic                  indirect,
   input  logic [DATA_W-1:0]     idx,
   input  logic [DATA_W-1:0]     ptr_low,
   input  logic [DATA_W-1:0]     ptr_high,
   input  logic [DATA_W-1:0]     ptr_page,
   input  logic [DATA_W-1:0]     ind_hi,
   output logic [3*DATA_W-1:0]   addr
);

   logic [DATA_W-1:0] ind_top;

   // variant: indirect accesses either share the pointer page or sit in page zero
   if (INDIRECT_PAGE) begin : g_shared_page
      assign ind_top = ptr_page;
   end else begin : g_page_zero
      assign ind_top = '0;
   end

   assign addr = indirect ? {ind_top, ind_hi, idx}
                          : {ptr_page, ptr_high, ptr_low};

endmodule

// File: rtl/xmem_xfer_fsm.sv
module xmem_xfer_fsm
   import xmem_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int STRETCH_W = 3,
   parameter int ADDR_W    = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    next_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [STRETCH_W-1:0] stretch,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic                 busy,
   output logic                 done,
   output logic [DATA_W-1:0]    rdata,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   output logic                 mem_drive,
   output logic                 mem_rd,
   output logic                 mem_wr
);

   xfer_state_t          state_q;
   logic [STRETCH_W-1:0] cnt_q;
   logic                 wr_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [DATA_W-1:0]    rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cnt_q   <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            XS_IDLE: begin
               if (req_valid) begin
                  state_q <= XS_SETUP;
                  wr_q    <= req_write;
                  addr_q  <= next_addr;
                  wdata_q <= req_wdata;
                  cnt_q   <= stretch;
               end
            end
            XS_SETUP: state_q <= XS_STROBE;
            XS_STROBE: begin
               if (cnt_q == '0) begin
                  state_q <= XS_TAIL;
                  if (!wr_q) rdata_q <= mem_rdata;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            XS_TAIL: state_q <= XS_IDLE;
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != XS_IDLE);
   assign done      = (state_q == XS_TAIL);
   assign mem_rd    = (state_q == XS_STROBE) && !wr_q;
   assign mem_wr    = (state_q == XS_STROBE) && wr_q;
   assign mem_drive = busy && wr_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign rdata     = rdata_q;

endmodule

// File: rtl/xmem_pager.sv
module xmem_pager #(
   parameter int DATA_W        = 8,
   parameter int NUM_PTR       = 2,
   parameter int STRETCH_W     = 3,
   parameter bit INDIRECT_PAGE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [2:0]            reg_sel,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic                  req_indirect,
   input  logic [DATA_W-1:0]     req_idx,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  busy,
   output logic                  done,
   output logic [DATA_W-1:0]     rdata,
   output logic [3*DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic                  mem_drive,
   output logic                  mem_rd,
   output logic                  mem_wr,
   input  logic [DATA_W-1:0]     mem_rdata
);

   localparam int ADDR_W = 3 * DATA_W;
   localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

   if (NUM_PTR < 1 || NUM_PTR > 4) begin : g_bad_ptr
      $error("NUM_PTR must lie in 1..4");
   end
   if (STRETCH_W < 1 || STRETCH_W > DATA_W) begin : g_bad_stretch
      $error("STRETCH_W must lie in 1..DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end

   logic [DATA_W-1:0]    cur_low, cur_high, cur_page, ind_hi;
   logic [STRETCH_W-1:0] cur_stretch;
   logic [ADDR_W-1:0]    next_addr;

   xmem_ptr_regs #(
      .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .STRETCH_W(STRETCH_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
      .rdata(reg_rdata), .cur_low(cur_low), .cur_high(cur_high),
      .cur_page(cur_page), .ind_hi(ind_hi), .stretch(cur_stretch)
   );

   xmem_addr_form #(
      .DATA_W(DATA_W), .INDIRECT_PAGE(INDIRECT_PAGE)
   ) u_addr (
      .indirect(req_indirect), .idx(req_idx), .ptr_low(cur_low),
      .ptr_high(cur_high), .ptr_page(cur_page), .ind_hi(ind_hi),
      .addr(next_addr)
   );

   xmem_xfer_fsm #(
      .DATA_W(DATA_W), .STRETCH_W(STRETCH_W), .ADDR_W(ADDR_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .next_addr(next_addr), .req_wdata(req_wdata), .stretch(cur_stretch),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .rdata(rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_drive(mem_drive),
      .mem_rd(mem_rd), .mem_wr(mem_wr)
   );

endmodule

// File: rtl/xmem_pager_chk.sv
module xmem_pager_chk #(
   parameter int STRETCH_W = 3,
   parameter int ADDR_W    = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_drive,
   input logic [ADDR_W-1:0] mem_addr
);

   logic               strobe;
   logic [STRETCH_W:0] strobe_len_q;

   assign strobe = mem_rd || mem_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      strobe_len_q <= '0;
      else if (strobe) strobe_len_q <= strobe_len_q + 1'b1;
      else             strobe_len_q <= '0;
   end

   // R6
   no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R6
   strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> busy);

   // R6
   strobe_max_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (strobe_len_q < (STRETCH_W+1)'(1 << STRETCH_W)));

   // R7
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !mem_drive);

   // R7
   write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_drive);

   // R8
   done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> done);

   // R9
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R10
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

bind xmem_pager xmem_pager_chk #(
   .STRETCH_W(STRETCH_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .mem_drive(mem_drive), .mem_addr(mem_addr)
);

// File: tb/xmem_pager_tb.sv
`timescale 1ns/1ps
module xmem_pager_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0;
   logic [7:0]  req_idx = 8'd0, req_wdata = 8'd0;
   logic        busy, done, mem_drive, mem_rd, mem_wr;
   logic [7:0]  rdata, mem_wdata, mem_rdata;
   logic [23:0] mem_addr;

   int checks = 0;
   int errors = 0;
   int n_done = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] memf(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
   endfunction

   assign mem_rdata = mem_rd ? memf(mem_addr) : 8'h00;

   xmem_pager u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_write(req_write), .req_indirect(req_indirect), .req_idx(req_idx),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_drive(mem_drive),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata)
   );

   // behavioural reference model
   int          m_st;   // 0 idle, 1 setup, 2 strobe, 3 tail
   int          m_cnt;
   bit          m_wr, m_ind;
   logic [23:0] m_addr;
   logic [7:0]  m_wdata;
   logic [7:0]  m_low [2], m_high [2], m_page [2];
   logic [7:0]  m_ihi;
   logic [2:0]  m_str;
   int          m_psel;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_wr = 0; m_ind = 0; m_addr = '0; m_wdata = '0;
         for (int i = 0; i < 2; i++) begin
            m_low[i] = '0; m_high[i] = '0; m_page[i] = '0;
         end
         m_ihi = '0; m_str = '0; m_psel = 0;
      end else begin
         case (m_st)
            0: if (req_valid) begin
                  m_st = 1; m_wr = req_write; m_ind = req_indirect;
                  m_addr = req_indirect ? {m_page[m_psel], m_ihi, req_idx}
                                        : {m_page[m_psel], m_high[m_psel], m_low[m_psel]};
                  m_wdata = req_wdata; m_cnt = m_str;
               end
            1: m_st = 2;
            2: if (m_cnt == 0) m_st = 3; else m_cnt--;
            default: m_st = 0;
         endcase
         if (reg_we) begin
            case (reg_sel)
               3'd0: m_low[m_psel]  = reg_wdata;
               3'd1: m_high[m_psel] = reg_wdata;
               3'd2: m_page[m_psel] = reg_wdata;
               3'd3: m_ihi = reg_wdata;
               3'd4: m_str = reg_wdata[2:0];
               3'd5: m_psel = int'(reg_wdata[0]);
               default: ;
            endcase
         end
      end
   end

   function automatic logic [7:0] exp_reg(input logic [2:0] s);
      case (s)
         3'd0: return m_low[m_psel];
         3'd1: return m_high[m_psel];
         3'd2: return m_page[m_psel];
         3'd3: return m_ihi;
         3'd4: return {5'd0, m_str};
         3'd5: return {7'd0, m_psel[0]};
         default: return 8'd0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (done) n_done++;
      if (!rst_n) begin
         chk("R1", {busy, done, mem_rd, mem_wr, mem_drive}, 0);
         chk("R1", reg_rdata, 0);
      end else begin
         chk("R9", busy, m_st != 0);
         chk("R8", done, m_st == 3);
         chk("R6", mem_rd, m_st == 2 && !m_wr);
         chk("R6", mem_wr, m_st == 2 && m_wr);
         chk("R7", mem_drive, m_st != 0 && m_wr);
         chk("R2", reg_rdata, exp_reg(reg_sel));
         if (m_st != 0) chk(m_ind ? "R5" : "R4", mem_addr, m_addr);
         if (m_st != 0 && m_wr) chk("R7", mem_wdata, m_wdata);
         if (m_st == 3 && !m_wr) chk("R8", rdata, memf(m_addr));
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic wreg(input logic [2:0] s, input logic [7:0] v);
      reg_we = 1'b1; reg_sel = s; reg_wdata = v;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_st != 0) tick();
   endtask

   task automatic xfer(input bit w, input bit ind, input logic [7:0] idx, input logic [7:0] d);
      req_valid = 1'b1; req_write = w; req_indirect = ind; req_idx = idx; req_wdata = d;
      tick();
      req_valid = 1'b0;
      wait_idle();
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int dn;
      logic [23:0] held;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", busy, 0);
      chk("R1", mem_drive, 0);
      @(posedge clk); #2 rst_n = 1'b1;
      tick();

      // R4 direct read, shortest strobe
      wreg(3'd2, 8'h56); wreg(3'd1, 8'h12); wreg(3'd0, 8'h34); wreg(3'd4, 8'h00);
      xfer(0, 0, 8'h00, 8'h00);
      // R6 R7 direct write, longest strobe
      wreg(3'd4, 8'hFF);
      reg_sel = 3'd4; @(negedge clk); chk("R2", reg_rdata, 8'h07); tick();
      xfer(1, 0, 8'h00, 8'hA5);

      // R3 second pointer set
      wreg(3'd5, 8'h01); wreg(3'd0, 8'h9C); wreg(3'd1, 8'h77); wreg(3'd2, 8'h0E);
      reg_sel = 3'd0; @(negedge clk); chk("R3", reg_rdata, 8'h9C); tick();
      xfer(0, 0, 8'h00, 8'h00);
      wreg(3'd5, 8'h00);
      reg_sel = 3'd0; @(negedge clk); chk("R3", reg_rdata, 8'h34); tick();
      reg_sel = 3'd2; @(negedge clk); chk("R3", reg_rdata, 8'h56); tick();

      // R2 unused codes ignored
      wreg(3'd6, 8'hFF); wreg(3'd7, 8'hFF);
      reg_sel = 3'd6; @(negedge clk); chk("R2", reg_rdata, 8'h00); tick();
      reg_sel = 3'd1; @(negedge clk); chk("R2", reg_rdata, 8'h12); tick();

      // R5 indirect read and write
      wreg(3'd3, 8'hC3); wreg(3'd4, 8'h03);
      xfer(0, 1, 8'h5D, 8'h00);
      xfer(1, 1, 8'hE2, 8'h3B);

      // R9 requests while busy are ignored
      req_valid = 1'b1; req_write = 1'b1; req_indirect = 1'b0; req_wdata = 8'h66;
      tick();
      req_write = 1'b0; req_indirect = 1'b1; req_idx = 8'hAA;
      repeat (3) tick();
      req_valid = 1'b0;
      wait_idle(); tick();
      chk("R9", busy, 0);

      // R9 held request: dropped in done cycle, accepted in next idle cycle
      wreg(3'd4, 8'h01);
      dn = n_done;
      req_valid = 1'b1; req_write = 1'b1; req_indirect = 1'b0; req_wdata = 8'h11;
      repeat (6) tick();
      req_valid = 1'b0;
      wait_idle(); tick();
      chk("R9", n_done - dn, 2);

      // R10 register writes during a transfer
      wreg(3'd4, 8'h05);
      req_valid = 1'b1; req_write = 1'b0; req_indirect = 1'b0;
      tick();
      req_valid = 1'b0;
      held = 24'h561234;
      wreg(3'd0, 8'hEE); wreg(3'd2, 8'hDD); wreg(3'd4, 8'h00);
      @(negedge clk); chk("R10", mem_addr, held); chk("R10", mem_rd, 1);
      tick();
      wait_idle(); tick();

      // sweep every stretch value across modes
      for (int s = 0; s < 8; s++) begin
         wreg(3'd4, 8'(s));
         xfer(s[0], s[1], 8'(s * 37), 8'(s * 11 + 1));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule